// File: doc/BRIEF.md
# Variable-Length Instruction Fetch Decoder

This block sits at the front of a simple sequential processor. Each cycle it receives the current program counter and a six-byte window that instruction memory returned from that address. It decodes the leading byte into an opcode and a function code, then decides from the opcode whether a register-specifier byte follows and whether a 32-bit constant is present. When a constant is present it sits either straight after the leading byte or after the register byte, depending on the opcode.

From the same opcode the block works out the instruction length and produces the address of the next sequential instruction. It raises an invalid flag for unknown opcodes and for illegal function codes. Fields that the instruction does not carry are driven to fixed defaults: register code 8 means no register, and the constant defaults to zero. By default the outputs pass through one register stage. A parameter selects a purely combinational path instead.

Top module: `insn_fetch_split`

## Requirements
- R1: `icode` is bits 7:4 of byte 0 and `ifun` is bits 3:0 of byte 0. Byte k of the window sits at `insnBytes[8k+7:8k]`. Both fields are passed through even when the instruction is invalid.
- R2: For opcodes 2, 3, 4, 5, 6, 0xA and 0xB, `rA` is bits 7:4 of byte 1 and `rB` is bits 3:0 of byte 1. For every other opcode both outputs read 8.
- R3: For opcodes 3, 4 and 5, `valC` is bytes 2..5 and for opcodes 7 and 8 it is bytes 1..4. In both cases it is assembled little-endian, so the lowest-addressed byte lands in `valC[7:0]`. For every other opcode `valC` is 0.
- R4: `valP` is `pc` plus the instruction length, wrapping modulo 2^ADDR_W. The lengths are: 1 for opcodes 0, 1 and 9; 2 for opcodes 2, 6, 0xA and 0xB; 5 for opcodes 7 and 8; 6 for opcodes 3, 4 and 5.
- R5: `invalid` is 1 in any of these cases: the opcode is above 0xB; opcode 6 has an `ifun` above 3; opcode 7 has an `ifun` above 6; any other opcode has a non-zero `ifun`. Otherwise `invalid` is 0.
- R6: While `invalid` is 1, `rA` and `rB` read 8, `valC` reads 0 and the length is taken as 1.
- R7: With REG_OUT=1, the outputs reflect the inputs sampled at the previous rising clock edge and hold between edges. During reset the outputs read `icode`=0, `ifun`=0, `rA`=8, `rB`=8, `valC`=0, `valP`=0 and `invalid`=0.
- R8: Window bytes that lie beyond the decoded instruction's length have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low synchronous reset |
| pc | input | ADDR_W | Address of byte 0 of the window |
| insnBytes | input | 48 | Six instruction bytes; byte k at bits 8k+7:8k |
| icode | output | 4 | Opcode nibble |
| ifun | output | 4 | Function nibble |
| rA | output | 4 | First register specifier, 8 when absent |
| rB | output | 4 | Second register specifier, 8 when absent |
| valC | output | 32 | Constant word, 0 when absent |
| valP | output | ADDR_W | Address of the next sequential instruction |
| invalid | output | 1 | Illegal opcode or function code |

## Verification
Two functions can act on the same bytes in the same cycle: extracting the register byte and placing the constant. For opcodes 3 to 5, byte 1 must feed `rA`/`rB` at the same time as bytes 2..5 feed `valC`. For opcodes 7 and 8, that same byte 1 must instead become the low byte of `valC`. The bench provokes this overlap by feeding every opcode with the same busy byte patterns back to back, by repeating instructions with only their trailing bytes altered, and by sweeping program counters near the top of the address space. A behavioural model built from the requirements judges every field of every cycle.

// File: rtl/ifd_pkg.sv
package ifd_pkg;
  localparam int WIN_BYTES = 6;
  localparam int WIN_W     = WIN_BYTES * 8;
  localparam int CONST_W   = 32;

  localparam logic [3:0] OP_NOP   = 4'h0;
  localparam logic [3:0] OP_HALT  = 4'h1;
  localparam logic [3:0] OP_RRMOV = 4'h2;
  localparam logic [3:0] OP_IRMOV = 4'h3;
  localparam logic [3:0] OP_RMMOV = 4'h4;
  localparam logic [3:0] OP_MRMOV = 4'h5;
  localparam logic [3:0] OP_ALU   = 4'h6;
  localparam logic [3:0] OP_JUMP  = 4'h7;
  localparam logic [3:0] OP_CALL  = 4'h8;
  localparam logic [3:0] OP_RET   = 4'h9;
  localparam logic [3:0] OP_PUSH  = 4'hA;
  localparam logic [3:0] OP_POP   = 4'hB;

  localparam logic [3:0] ALU_FN_MAX  = 4'h3;
  localparam logic [3:0] JUMP_FN_MAX = 4'h6;
  localparam logic [3:0] NO_REG      = 4'h8;

  // Strobes from control to datapath
  typedef struct packed {
    logic       regByte;    // register byte follows byte 0
    logic       constWord;  // 32-bit constant present
    logic       constLate;  // constant starts at byte 2 instead of byte 1
    logic [2:0] len;        // instruction length in bytes
  } fetchStrobe_t;
endpackage

// File: rtl/ifd_ctrl.sv
module ifd_ctrl
  import ifd_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic [7:0]   lead,
  output fetchStrobe_t stb,
  output logic         bad
);
  logic [3:0] op;
  logic [3:0] fn;
  assign op = lead[7:4];
  assign fn = lead[3:0];

  always_comb begin
    bad = 1'b0;
    stb = '{regByte: 1'b0, constWord: 1'b0, constLate: 1'b0, len: 3'd1};
    case (op)
      OP_NOP, OP_HALT, OP_RET: bad = (fn != 4'h0);
      OP_RRMOV, OP_PUSH, OP_POP: begin
        stb.regByte = 1'b1;
        stb.len     = 3'd2;
        bad         = (fn != 4'h0);
      end
      OP_IRMOV, OP_RMMOV, OP_MRMOV: begin
        stb.regByte   = 1'b1;
        stb.constWord = 1'b1;
        stb.constLate = 1'b1;
        stb.len       = 3'd6;
        bad           = (fn != 4'h0);
      end
      OP_ALU: begin
        stb.regByte = 1'b1;
        stb.len     = 3'd2;
        bad         = (fn > ALU_FN_MAX);
      end
      OP_JUMP: begin
        stb.constWord = 1'b1;
        stb.len       = 3'd5;
        bad           = (fn > JUMP_FN_MAX);
      end
      OP_CALL: begin
        stb.constWord = 1'b1;
        stb.len       = 3'd5;
        bad           = (fn != 4'h0);
      end
      default: bad = 1'b1;
    endcase
    if (bad) begin
      stb = '{regByte: 1'b0, constWord: 1'b0, constLate: 1'b0, len: 3'd1};
    end
  end

  // R6: an illegal instruction carries no optional fields and is one byte long
  a_r6_bad_bare: assert property (@(posedge clk) disable iff (!rst_n)
    bad |-> (!stb.regByte && !stb.constWord && stb.len == 3'd1));
  // R4: only the four legal lengths occur
  a_r4_len_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.len == 3'd1 || stb.len == 3'd2 || stb.len == 3'd5 || stb.len == 3'd6));
  // R3: a constant without a register byte starts at byte 1 and gives length 5
  a_r3_early_const: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.constWord && !stb.regByte) |-> (!stb.constLate && stb.len == 3'd5));
  // R5: unknown opcodes are always flagged
  a_r5_high_op: assert property (@(posedge clk) disable iff (!rst_n)
    (op > OP_POP) |-> bad);
endmodule

// File: rtl/ifd_dpath.sv
module ifd_dpath
  import ifd_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter bit REG_OUT = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  pc,
  input  logic [WIN_W-1:0]   win,
  input  fetchStrobe_t       stb,
  input  logic               badIn,
  output logic [3:0]         icode,
  output logic [3:0]         ifun,
  output logic [3:0]         rA,
  output logic [3:0]         rB,
  output logic [CONST_W-1:0] valC,
  output logic [ADDR_W-1:0]  valP,
  output logic               invalid
);
  logic [3:0]         icodeNext, ifunNext, rANext, rBNext;
  logic [CONST_W-1:0] valCNext;
  logic [ADDR_W-1:0]  valPNext;

  always_comb begin
    icodeNext = win[7:4];
    ifunNext  = win[3:0];
    rANext    = stb.regByte ? win[15:12] : NO_REG;
    rBNext    = stb.regByte ? win[11:8]  : NO_REG;
    if (!stb.constWord)      valCNext = '0;
    else if (stb.constLate)  valCNext = win[16 +: CONST_W];
    else                     valCNext = win[8 +: CONST_W];
    valPNext = pc + ADDR_W'(stb.len);
  end

  generate
    if (REG_OUT) begin : g_reg
      logic primed;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          icode <= '0; ifun <= '0; rA <= NO_REG; rB <= NO_REG;
          valC <= '0; valP <= '0; invalid <= 1'b0; primed <= 1'b0;
        end else begin
          icode <= icodeNext; ifun <= ifunNext; rA <= rANext; rB <= rBNext;
          valC <= valCNext; valP <= valPNext; invalid <= badIn; primed <= 1'b1;
        end
      end
      // R4: next address steps by a legal length from the previous cycle's pc
      a_r4_valp_step: assert property (@(posedge clk) disable iff (!rst_n)
        primed |-> ((valP - $past(pc)) == ADDR_W'(1) || (valP - $past(pc)) == ADDR_W'(2) ||
                    (valP - $past(pc)) == ADDR_W'(5) || (valP - $past(pc)) == ADDR_W'(6)));
    end else begin : g_comb
      assign icode = icodeNext;  assign ifun = ifunNext;
      assign rA = rANext;        assign rB = rBNext;
      assign valC = valCNext;    assign valP = valPNext;
      assign invalid = badIn;
      a_r4_valp_step: assert property (@(posedge clk) disable iff (!rst_n)
        ((valP - pc) == ADDR_W'(1) || (valP - pc) == ADDR_W'(2) ||
         (valP - pc) == ADDR_W'(5) || (valP - pc) == ADDR_W'(6)));
    end
  endgenerate

  // R6: flagged instructions show default register codes and a zero constant
  a_r6_bad_defaults: assert property (@(posedge clk) disable iff (!rst_n)
    invalid |-> (rA == NO_REG && rB == NO_REG && valC == '0));
endmodule

// File: rtl/insn_fetch_split.sv
module insn_fetch_split
  import ifd_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] pc,
  input  logic [47:0]       insnBytes,
  output logic [3:0]        icode,
  output logic [3:0]        ifun,
  output logic [3:0]        rA,
  output logic [3:0]        rB,
  output logic [31:0]       valC,
  output logic [ADDR_W-1:0] valP,
  output logic              invalid
);
  fetchStrobe_t stb;
  logic         bad;

  ifd_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .lead(insnBytes[7:0]), .stb(stb), .bad(bad)
  );

  ifd_dpath #(.ADDR_W(ADDR_W), .REG_OUT(REG_OUT)) u_dpath (
    .clk(clk), .rst_n(rst_n), .pc(pc), .win(insnBytes), .stb(stb), .badIn(bad),
    .icode(icode), .ifun(ifun), .rA(rA), .rB(rB), .valC(valC), .valP(valP),
    .invalid(invalid)
  );
endmodule

// File: tb/insn_fetch_split_test.sv
module insn_fetch_split_test;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] pc;
  logic [47:0]   insnBytes;
  logic [3:0]    icode, ifun, rA, rB;
  logic [31:0]   valC;
  logic [AW-1:0] valP;
  logic          invalid;

  int total = 0;
  int bad = 0;

  typedef struct packed {
    logic [3:0] ic, fn, ra, rb;
    logic [31:0] c;
    logic [AW-1:0] p;
    logic inv;
  } exp_t;

  exp_t held;

  always #10 clk = ~clk;

  insn_fetch_split #(.ADDR_W(AW), .REG_OUT(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .pc(pc), .insnBytes(insnBytes),
    .icode(icode), .ifun(ifun), .rA(rA), .rB(rB), .valC(valC), .valP(valP),
    .invalid(invalid)
  );

  // Behavioural model written from the requirements
  function automatic exp_t model(input logic [AW-1:0] a, input logic [47:0] w);
    exp_t e;
    int op, fn, len, cpos;
    bit reg_on, ill;
    op = int'(w[7:4]); fn = int'(w[3:0]);
    reg_on = 0; cpos = 0; len = 1; ill = 0;
    if (op == 0 || op == 1 || op == 9) ill = (fn != 0);
    else if (op == 2 || op == 10 || op == 11) begin reg_on = 1; len = 2; ill = (fn != 0); end
    else if (op >= 3 && op <= 5) begin reg_on = 1; cpos = 2; len = 6; ill = (fn != 0); end
    else if (op == 6) begin reg_on = 1; len = 2; ill = (fn > 3); end
    else if (op == 7) begin cpos = 1; len = 5; ill = (fn > 6); end
    else if (op == 8) begin cpos = 1; len = 5; ill = (fn != 0); end
    else ill = 1;
    if (ill) begin reg_on = 0; cpos = 0; len = 1; end
    e.ic = w[7:4]; e.fn = w[3:0];
    e.ra = reg_on ? w[15:12] : 4'h8;
    e.rb = reg_on ? w[11:8]  : 4'h8;
    e.c = 32'h0;
    for (int k = 0; k < 4; k++) begin
      if (cpos != 0) e.c[8*k +: 8] = w[8*(cpos+k) +: 8];
    end
    e.p = a + AW'(len);
    e.inv = ill;
    return e;
  endfunction

  function automatic string tag_of(input exp_t e);
    if (e.inv) return "R5 R6";
    if (e.c != 0 || e.ic inside {4'h3, 4'h4, 4'h5, 4'h7, 4'h8}) return "R3 R4";
    if (e.ra != 4'h8 || e.rb != 4'h8 || e.ic inside {4'h2, 4'h6}) return "R1 R2";
    return "R1 R4";
  endfunction

  task automatic compare(input exp_t e, input string tag);
    exp_t got;
    got = '{ic: icode, fn: ifun, ra: rA, rb: rB, c: valC, p: valP, inv: invalid};
    total++;
    if (got !== e) begin
      bad++;
      $display("FAIL %s: got ic=%h fn=%h rA=%h rB=%h valC=%h valP=%h inv=%b exp ic=%h fn=%h rA=%h rB=%h valC=%h valP=%h inv=%b",
               tag, got.ic, got.fn, got.ra, got.rb, got.c, got.p, got.inv,
               e.ic, e.fn, e.ra, e.rb, e.c, e.p, e.inv);
    end
  endtask

  // Drive at a falling edge; outputs must hold until the rising edge (R7),
  // then show the new result at the next falling edge.
  task automatic apply(input logic [AW-1:0] a, input logic [47:0] w, input string tagOverride);
    exp_t e;
    pc = a; insnBytes = w;
    e = model(a, w);
    #3;
    compare(held, "R7 hold");
    @(negedge clk);
    compare(e, (tagOverride != "") ? tagOverride : tag_of(e));
    held = e;
  endtask

  task automatic summary;
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    #(20 * 100000);
    bad++;
    $display("FAIL watchdog: got timeout exp completion");
    summary();
    $finish;
  end

  initial begin
    logic [47:0] busy;
    rst_n = 1'b0; pc = 32'h1234; insnBytes = 48'hA5A5_5A5A_3C3C;
    repeat (3) @(negedge clk);
    // R7: reset values
    held = '{ic: 4'h0, fn: 4'h0, ra: 4'h8, rb: 4'h8, c: 32'h0, p: '0, inv: 1'b0};
    compare(held, "R7 reset");
    rst_n = 1'b1;

    // Every opcode and several function codes over a busy byte pattern
    busy = 48'hF1E2_D3C4_B5A6;
    for (int op = 0; op < 16; op++) begin
      foreach (busy[i]) begin end
      for (int f = 0; f < 8; f++) begin
        logic [3:0] fn;
        fn = (f == 7) ? 4'hF : 4'(f);
        apply(32'h0000_1000 + 32'(op * 64 + f), {busy[47:8], 4'(op), fn}, "");
      end
    end

    // R3: constant placement for each constant-bearing opcode
    apply(32'h100, 48'h7856_3412_4530, "R3 irmov");
    apply(32'h100, 48'hEFCD_AB89_1240, "R3 rmmov");
    apply(32'h100, 48'h0403_0201_6750, "R3 mrmov");
    apply(32'h100, 48'h0044_3322_1173, "R3 jump");
    apply(32'h100, 48'h00DD_CCBB_AA80, "R3 call");

    // R4: wrap of the next address near the top of the space
    apply(32'hFFFF_FFFE, 48'h0000_0000_0010, "R4 wrap len1");
    apply(32'hFFFF_FFFF, 48'h0000_0000_0160, "R4 wrap len2");
    apply(32'hFFFF_FFFC, 48'h0000_0000_0070, "R4 wrap len5");
    apply(32'hFFFF_FFFB, 48'h0000_0000_0030, "R4 wrap len6");

    // R8: trailing bytes beyond the instruction do not matter
    apply(32'h200, 48'h0000_0000_2320, "R8 rrmov zero tail");
    apply(32'h200, 48'hFFFF_FFFF_2320, "R8 rrmov full tail");
    apply(32'h300, 48'h1234_5678_9A90, "R8 ret tail");
    apply(32'h400, 48'hFF11_2233_4470, "R8 jump tail");
    apply(32'h500, 48'hAAAA_AAAA_0561, "R8 alu tail");

    // R5: function-code boundaries
    apply(32'h600, 48'h0000_0000_0063, "R5 alu fn3 ok");
    apply(32'h600, 48'h0000_0000_0064, "R5 alu fn4 bad");
    apply(32'h600, 48'h0000_0000_0076, "R5 jump fn6 ok");
    apply(32'h600, 48'h0000_0000_0077, "R5 jump fn7 bad");
    apply(32'h600, 48'h1111_1111_11C0, "R5 R6 op C");

    // Random mix
    for (int n = 0; n < 400; n++) begin
      logic [47:0] w;
      w = {$urandom(), 16'($urandom())};
      if (n % 3 != 0) w[3:0] = 4'h0;
      apply($urandom(), w, "");
    end

    summary();
    $finish;
  end
endmodule